// File: doc/BRIEF.md
# Two-Cell Receive Buffer with Selectable Flow Control

This block sits between a receive path that produces fixed-length cells one byte at a time and a downstream consumer that pulls those bytes over a byte-wide port. Both sides run on the receive clock. Storage is organised as a small FIFO of whole cells. Space is claimed when the first byte of a cell arrives and is returned only when the last byte of that cell has been read out. A cell is shown to the consumer only once it is complete, so the consumer never stalls partway through a cell because the producer has not finished it.

The consumer pulls bytes by holding an active-low read enable. Each byte it receives is flagged valid, and the first byte of every cell also carries a start-of-cell marker. A static mode input selects how readiness is reported on a single flag pin. In byte-level mode the pin is an active-low empty flag: it is high whenever unread bytes of a visible cell remain. In cell-level mode the pin is a cell-available flag: it is high when at least one complete cell is stored that the consumer has not yet started. If a new cell arrives while every slot is taken, that cell is discarded in full and a one-cycle overflow pulse is raised.

Top module: `cell_rx_buffer`

## Requirements
- R1: After reset, the flag output, rd_valid_o, rd_sop_o and ovf_o are all 0.
- R2: A cell stays invisible until all CELL_BYTES (default 53) of its bytes have been written. Until then the flag stays at its no-data value and reads return nothing. Cell boundaries are counted from reset, one cell per CELL_BYTES accepted write strobes.
- R3: When the first byte of a new cell arrives and all NUM_CELLS (default 2) slots hold visible cells, every byte of that cell is discarded. ovf_o is high for exactly the one cycle after that first byte's edge.
- R4: At each rising edge where rd_en_n_i is 0 and a visible cell exists, one byte is delivered. It appears on rd_data_o with rd_valid_o = 1 after that edge.
- R5: rd_sop_o is 1 exactly when the delivered byte is byte 0 of a cell.
- R6: When mode_i = 0 (byte level), the flag is 1 while any unread byte of a visible cell remains, and 0 otherwise.
- R7: When mode_i = 1 (cell level), the flag is 1 while a visible cell exists whose byte 0 has not yet been read, and 0 otherwise.
- R8: A read while no visible cell exists has no effect. rd_valid_o stays 0 and the next delivered byte is unchanged.
- R9: Deasserting rd_en_n_i mid-cell pauses the transfer. On resume, delivery continues with the next byte of the same cell.
- R10: The buffer holds at most NUM_CELLS cells and delivers them in write order with their bytes unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Flow-control style: 0 byte level, 1 cell level |
| wr_valid_i | input | 1 | Write strobe for one incoming cell byte |
| wr_data_i | input | DATA_W | Incoming cell byte |
| ovf_o | output | 1 | One-cycle pulse when an arriving cell is dropped |
| rd_en_n_i | input | 1 | Active-low read enable from the consumer |
| rd_data_o | output | DATA_W | Delivered byte |
| rd_valid_o | output | 1 | rd_data_o holds a byte delivered at the last edge |
| rd_sop_o | output | 1 | Delivered byte is byte 0 of a cell |
| flag_o | output | 1 | Readiness: not-empty in byte mode, cell-available in cell mode |

## Verification
A delivered byte, together with its valid and start-of-cell markers, is due one rising edge after the edge that sampled rd_en_n_i low. The overflow pulse is due one edge after the dropped cell's first byte. The flag is decoded from registered state, so it reflects a commit or a release right after the edge that caused it: a cell becomes visible after the edge that takes its last byte. The bench drives inputs and samples all outputs on the falling edge. It advances a cycle-accurate model built from the requirements by one step per rising edge, so each comparison meets the value due for that edge.

// File: rtl/cellbuf_pkg.sv
package cellbuf_pkg;
   typedef enum logic {
      HS_BYTE = 1'b0,
      HS_CELL = 1'b1
   } hs_mode_e;
endpackage

// File: rtl/cellbuf_store.sv
module cellbuf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 106,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/cellbuf_wr_ctrl.sv
module cellbuf_wr_ctrl #(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int NUM_CELLS  = 2,
   localparam int IDX_W  = $clog2(CELL_BYTES),
   localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
   localparam int CNT_W  = $clog2(NUM_CELLS + 1),
   localparam int ADDR_W = $clog2(NUM_CELLS * CELL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [CNT_W-1:0]  cells_i,
   output logic              we_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              commit_o,
   output logic              ovf_o
);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CELLS - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [SLOT_W-1:0] slot_q;
   logic              drop_q;
   logic              head;
   logic              room;

   assign head     = (idx_q == '0);
   assign room     = (cells_i != CNT_W'(NUM_CELLS));
   assign we_o     = wr_valid_i && (head ? room : !drop_q);
   assign commit_o = we_o && (idx_q == LAST_IDX);
   assign waddr_o  = ADDR_W'(slot_q) * ADDR_W'(CELL_BYTES) + ADDR_W'(idx_q);
   assign wdata_o  = wr_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         slot_q <= '0;
         drop_q <= 1'b0;
         ovf_o  <= 1'b0;
      end else begin
         ovf_o <= wr_valid_i && head && !room;
         if (wr_valid_i) begin
            if (head) drop_q <= !room;
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
         end
         if (commit_o) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
   end

   a_r3_ovf_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o);
   a_r3_drop_whole_cell: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_valid_i) && $past(idx_q == '0) && ovf_o) |-> drop_q);
endmodule

// File: rtl/cellbuf_rd_ctrl.sv
module cellbuf_rd_ctrl #(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int NUM_CELLS  = 2,
   localparam int IDX_W  = $clog2(CELL_BYTES),
   localparam int SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
   localparam int CNT_W  = $clog2(NUM_CELLS + 1),
   localparam int ADDR_W = $clog2(NUM_CELLS * CELL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_n_i,
   input  logic [CNT_W-1:0]  cells_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [ADDR_W-1:0] raddr_o,
   output logic              release_o,
   output logic              started_o,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_sop_o
);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CELLS - 1);

   logic [IDX_W-1:0]  idx_q;
   logic [SLOT_W-1:0] slot_q;
   logic              fire;

   assign fire      = !rd_en_n_i && (cells_i != '0);
   assign release_o = fire && (idx_q == LAST_IDX);
   assign started_o = (idx_q != '0);
   assign raddr_o   = ADDR_W'(slot_q) * ADDR_W'(CELL_BYTES) + ADDR_W'(idx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q      <= '0;
         slot_q     <= '0;
         rd_valid_o <= 1'b0;
         rd_sop_o   <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= fire;
         rd_sop_o   <= fire && (idx_q == '0);
         if (fire) begin
            rd_data_o <= mem_data_i;
            idx_q     <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
         end
         if (release_o) slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end
   end

   a_r8_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en_n_i && cells_i == '0) |=> !rd_valid_o);
   a_r4_byte_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en_n_i && cells_i != '0) |=> rd_valid_o);
   a_r5_sop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sop_o |-> rd_valid_o);
   a_r9_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_n_i |=> $stable(idx_q));
endmodule

// File: rtl/cell_rx_buffer.sv
module cell_rx_buffer
   import cellbuf_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter int NUM_CELLS  = 2,
   localparam int DEPTH  = NUM_CELLS * CELL_BYTES,
   localparam int CNT_W  = $clog2(NUM_CELLS + 1),
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              wr_valid_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              ovf_o,
   input  logic              rd_en_n_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              rd_sop_o,
   output logic              flag_o
);
   generate
      if (DATA_W < 1)      begin : g_bad_width $error("DATA_W must be positive"); end
      if (CELL_BYTES < 2)  begin : g_bad_cell  $error("CELL_BYTES must be at least 2"); end
      if (NUM_CELLS < 1)   begin : g_bad_depth $error("NUM_CELLS must be positive"); end
      if (DEPTH > 4096)    begin : g_too_big   $error("buffer too large"); end
   endgenerate

   logic [CNT_W-1:0]  cells_q;
   logic              commit, release_c, started;
   logic              we;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] wdata, rdata;
   hs_mode_e          mode;

   assign mode = hs_mode_e'(mode_i);

   cellbuf_wr_ctrl #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .NUM_CELLS(NUM_CELLS)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
      .cells_i(cells_q), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
      .commit_o(commit), .ovf_o(ovf_o));

   cellbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
      .raddr_i(raddr), .rdata_o(rdata));

   cellbuf_rd_ctrl #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .NUM_CELLS(NUM_CELLS)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en_n_i(rd_en_n_i), .cells_i(cells_q),
      .mem_data_i(rdata), .raddr_o(raddr), .release_o(release_c), .started_o(started),
      .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_sop_o(rd_sop_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells_q <= '0;
      else        cells_q <= cells_q + CNT_W'(commit) - CNT_W'(release_c);
   end

   always_comb begin
      unique case (mode)
         HS_BYTE: flag_o = (cells_q != '0);
         HS_CELL: flag_o = (cells_q > CNT_W'(started));
         default: flag_o = 1'b0;
      endcase
   end

   a_r10_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cells_q <= CNT_W'(NUM_CELLS));
   a_r10_commit_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (cells_q != CNT_W'(NUM_CELLS)) || release_c);
   a_r7_clav_needs_cell: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == HS_CELL && flag_o) |-> (cells_q != '0));
   a_r2_hidden_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cells_q == '0 && !commit) |=> !flag_o);
endmodule

// File: tb/cell_rx_buffer_bench.sv
module cell_rx_buffer_bench;
   localparam int CB = 53;
   localparam int NC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode = 1'b0;
   logic       wv = 1'b0;
   logic [7:0] wd = '0;
   logic       ren_n = 1'b1;
   logic       ovf, rv, rsop, flag;
   logic [7:0] rdat;

   cell_rx_buffer u_cell_rx_buffer (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_valid_i(wv), .wr_data_i(wd),
      .ovf_o(ovf), .rd_en_n_i(ren_n), .rd_data_o(rdat), .rd_valid_o(rv),
      .rd_sop_o(rsop), .flag_o(flag));

   always #10 clk = ~clk;

   int vectors = 0;
   int misses  = 0;
   bit done    = 0;
   string phase = "R1";

   // reference state, built from the requirements
   logic [7:0] m_mem [NC][CB];
   int m_cnt = 0, m_widx = 0, m_wslot = 0, m_ridx = 0, m_rslot = 0;
   bit m_drop = 0;
   bit e_valid = 0, e_sop = 0, e_ovf = 0;
   logic [7:0] e_data = '0;

   function automatic bit exp_flag();
      if (mode == 1'b0) return m_cnt > 0;
      return (m_cnt - ((m_ridx != 0) ? 1 : 0)) > 0;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", req, phase, $time, act, exp);
      end
   endtask

   task automatic compare();
      check(rv == e_valid, "R4/R8 valid", rv, e_valid);
      if (e_valid) begin
         check(rdat == e_data, "R10 data", rdat, e_data);
         check(rsop == e_sop, "R5 sop", rsop, e_sop);
      end
      check(ovf == e_ovf, "R3 ovf", ovf, e_ovf);
      check(flag == exp_flag(), mode ? "R7 flag" : "R6 flag", flag, exp_flag());
   endtask

   // Applies inputs at a falling edge, steps the model across the next rising edge.
   task automatic cycle(input bit w, input logic [7:0] d, input bit rn);
      bit rel, com, acc;
      wv = w; wd = d; ren_n = rn;
      rel = 0; com = 0; acc = 0;
      e_valid = 0; e_sop = 0; e_ovf = 0;
      if (!rn && m_cnt > 0) begin
         e_valid = 1; e_data = m_mem[m_rslot][m_ridx]; e_sop = (m_ridx == 0);
         rel = (m_ridx == CB - 1);
         m_ridx = rel ? 0 : m_ridx + 1;
      end
      if (w) begin
         if (m_widx == 0) begin
            acc = (m_cnt < NC); m_drop = !acc; e_ovf = !acc;
         end else acc = !m_drop;
         if (acc) m_mem[m_wslot][m_widx] = d;
         com = acc && (m_widx == CB - 1);
         m_widx = (m_widx == CB - 1) ? 0 : m_widx + 1;
      end
      if (rel) m_rslot = (m_rslot + 1) % NC;
      if (com) m_wslot = (m_wslot + 1) % NC;
      m_cnt = m_cnt + int'(com) - int'(rel);
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   initial begin
      int cnt_before;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(flag == 1'b0 && rv == 1'b0 && rsop == 1'b0 && ovf == 1'b0, "R1 reset", {flag, rv, rsop, ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare();

      // R8: reads with nothing stored
      phase = "R8";
      repeat (4) cycle(0, 8'h00, 0);
      check(rv == 1'b0, "R8 idle read", rv, 0);

      // R2: 52 bytes keep the cell hidden in both flag styles
      phase = "R2";
      for (int i = 0; i < CB - 1; i++) begin
         mode = i[0];
         cycle(1, 8'(i + 8'h40), 0);
      end
      mode = 1'b0;
      check(flag == 1'b0, "R2 hidden partial cell", flag, 0);
      cycle(1, 8'h99, 1);
      check(flag == 1'b1, "R2 visible after last byte", flag, 1);

      // R3: fill the second slot, then a third cell is dropped
      phase = "R3";
      for (int i = 0; i < CB; i++) cycle(1, 8'($urandom), 1);
      check(m_cnt == NC, "R3 model full", m_cnt, NC);
      cycle(1, 8'hEE, 1);
      check(ovf == 1'b1, "R3 pulse", ovf, 1);
      for (int i = 1; i < CB; i++) cycle(1, 8'hEE, 1);

      // R7/R9: cell mode, reading with pauses
      phase = "R9";
      mode = 1'b1;
      cycle(0, 0, 0);
      check(flag == 1'b1, "R7 second cell waiting", flag, 1);
      for (int i = 0; i < 2 * CB; i++) cycle(0, 0, (i % 7) == 3);
      cnt_before = m_cnt;
      repeat (6) cycle(0, 0, 1);
      check(rv == 1'b0, "R9 paused no delivery", rv, 0);
      while (m_cnt > 0) cycle(0, 0, 0);
      check(cnt_before >= 0 && flag == 1'b0, "R6/R7 drained", flag, 0);

      // random traffic with both flag styles
      phase = "R10";
      for (int blk = 0; blk < 6; blk++) begin
         mode = blk[0];
         for (int i = 0; i < 500; i++)
            cycle(($urandom % 10) < 7, 8'($urandom), ($urandom % 10) < (blk < 3 ? 4 : 7));
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule